// File: doc/BRIEF.md
# Strip-Mined Integer Reduce-Add Unit

This unit adds up a stream of signed integers into a single scalar. A start pulse supplies the element count; the unit then takes elements from a valid/ready stream. It works through them in chunks. Each chunk is as long as the maximum vector length parameter `MVL`, or as long as the number of elements still left, if that is smaller. Each chunk's sum is folded into a running accumulator that starts at zero. The work ends when no elements are left.

A mode bit, captured with the start pulse, selects how a chunk is reduced:
- **Sequential mode** adds every element to the accumulator as it arrives, strictly in index order.
- **Tree mode** collects the chunk into a lane buffer and zero-fills the unused lanes. It then folds the buffer in halves (lane i with lane i + half) until one lane is left. That lane is added to the accumulator.

Integer addition wraps, so both modes give bit-identical results. The length of each chunk is reported on its own output with a one-cycle marker.

Top module: `strip_reduce_add`

## Requirements
- R1: After reset, `done`, `elemReady` and `chunkStart` are 0 and `result` is 0.
- R2: `chunkStart` pulses for exactly one cycle at the first cycle of each chunk. While that chunk collects elements, `chunkLen` holds min(MVL, elements still remaining) and stays steady.
- R3: The chunk lengths follow the remaining count down to zero. For example, with MVL = 8 and n = 20 they are 8, 8, 4; with n = 16 they are 8, 8.
- R4: With `treeMode` = 0 at start, `result` at `done` equals the 32-bit sum of the n accepted elements.
- R5: With `treeMode` = 1 at start, `result` equals the same sum. This includes a final chunk shorter than MVL, whose unused lanes count as zero.
- R6: Sums wrap modulo 2^32 with no saturation, and both modes give the same bits.
- R7: A start with n = 0 raises `done` in the next cycle with `result` = 0, and no element is accepted.
- R8: `done` is a one-cycle pulse. `result` keeps its value after `done` until the next start.
- R9: `count` and `treeMode` are sampled only in the cycle of `start`. Later changes to them do not affect the run.
- R10: Exactly n elements are accepted. An element offered while `elemReady` is 0 is not taken and does not change the sum.
- R11: All of the above holds with MVL = 1, where every chunk has length 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted while idle) |
| count | input | CNT_W | Number of elements n |
| treeMode | input | 1 | 0 = sequential, 1 = pairwise tree reduction |
| elemValid | input | 1 | Element on `elemData` is offered |
| elemData | input | DATA_W | Signed element |
| elemReady | output | 1 | Unit takes an element this cycle when valid |
| result | output | DATA_W | Accumulated sum |
| done | output | 1 | One-cycle end-of-run pulse |
| chunkLen | output | $clog2(MVL+1) | Length of the current chunk |
| chunkStart | output | 1 | First cycle of a chunk |

## Verification
The same data is fed through both modes and through an MVL = 1 build. Any ordering or padding fault shows up as a sum mismatch between them.

The counts are chosen to tell apart specific failures:
- A count that is an exact multiple of MVL catches off-by-one chunk bookkeeping.
- A count smaller than MVL exercises zero padding in tree mode.
- A count of one checks the shortest possible run.
- A count of zero checks the early finish.

Data near the top of the signed range mixed with negative numbers checks wraparound. Stalls on the valid line, plus elements offered outside collection, separate correct handshaking from elements that are dropped or counted twice.

// File: rtl/sred_pkg.sv
package sred_pkg;

  typedef struct packed {
    logic capture;     // latch count and mode, clear accumulator
    logic chunkBegin;  // compute chunk length, clear lanes
    logic take;        // one element accepted
    logic fold;        // one tree level
    logic merge;       // add lane 0 into accumulator
    logic chunkEnd;    // subtract chunk length from remaining
  } sredStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_LOAD, S_FOLD, S_MERGE, S_FIN
  } sredState_t;

endpackage

// File: rtl/sred_datapath.sv
module sred_datapath
  import sred_pkg::*;
#(
  parameter int MVL    = 8,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  localparam int LEN_W = $clog2(MVL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sredStrobe_t       strobe,
  input  logic [CNT_W-1:0]  countIn,
  input  logic              treeIn,
  input  logic [DATA_W-1:0] elemData,
  output logic              treeQ,
  output logic              countZero,
  output logic              lastElem,
  output logic              lastLevel,
  output logic              lastChunk,
  output logic [DATA_W-1:0] acc,
  output logic [LEN_W-1:0]  lenQ,
  output logic              pulseQ
);

  localparam int IDX_W = (MVL > 1) ? $clog2(MVL) : 1;
  localparam int LVL   = $clog2(MVL);
  localparam int LVL_W = (LVL > 0) ? $clog2(LVL + 1) : 1;

  logic [CNT_W-1:0]  remaining;
  logic [LEN_W-1:0]  elemCnt;
  logic [LVL_W-1:0]  level;
  logic [LEN_W-1:0]  vlNext;
  logic [DATA_W-1:0] lanes   [MVL];
  logic [DATA_W-1:0] foldVal [MVL];

  assign vlNext    = (remaining < CNT_W'(MVL)) ? remaining[LEN_W-1:0] : LEN_W'(MVL);
  assign countZero = (countIn == '0);
  assign lastElem  = (elemCnt == lenQ - 1'b1);
  assign lastLevel = (LVL <= 1) ? 1'b1 : (level == LVL_W'(LVL - 1));
  assign lastChunk = (remaining == CNT_W'(lenQ));

  // Pairwise fold: at level l, lane i (i < stride) takes lane i + stride.
  always_comb begin
    for (int i = 0; i < MVL; i++) begin
      foldVal[i] = lanes[IDX_W'(i)];
      for (int l = 0; l < LVL; l++) begin
        if (level == LVL_W'(l) && i < (MVL >> (l + 1)))
          foldVal[i] = lanes[IDX_W'(i)] + lanes[IDX_W'((i + (MVL >> (l + 1))) % MVL)];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      remaining <= '0;
      treeQ     <= 1'b0;
      lenQ      <= '0;
      elemCnt   <= '0;
      level     <= '0;
      pulseQ    <= 1'b0;
    end else begin
      pulseQ <= strobe.chunkBegin;
      if (strobe.capture) begin
        acc       <= '0;
        remaining <= countIn;
        treeQ     <= treeIn;
      end
      if (strobe.chunkBegin) begin
        lenQ    <= vlNext;
        elemCnt <= '0;
        level   <= '0;
      end
      if (strobe.take) begin
        elemCnt <= elemCnt + 1'b1;
        if (!treeQ) acc <= acc + elemData;
      end
      if (strobe.fold)     level     <= level + 1'b1;
      if (strobe.merge)    acc       <= acc + lanes[0];
      if (strobe.chunkEnd) remaining <= remaining - CNT_W'(lenQ);
    end
  end

  for (genvar g = 0; g < MVL; g++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        lanes[g] <= '0;
      else if (strobe.chunkBegin)
        lanes[g] <= '0;
      else if (strobe.take && treeQ && elemCnt == LEN_W'(g))
        lanes[g] <= elemData;
      else if (strobe.fold)
        lanes[g] <= foldVal[g];
    end
  end

endmodule

// File: rtl/sred_control.sv
module sred_control
  import sred_pkg::*;
#(
  parameter int MVL = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        countZero,
  input  logic        treeQ,
  input  logic        elemValid,
  input  logic        lastElem,
  input  logic        lastLevel,
  input  logic        lastChunk,
  output sredStrobe_t strobe,
  output logic        elemReady,
  output logic        done
);

  sredState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    elemReady = 1'b0;
    done      = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          strobe.capture = 1'b1;
          stateNext = countZero ? S_FIN : S_SETUP;
        end
      end
      S_SETUP: begin
        strobe.chunkBegin = 1'b1;
        stateNext = S_LOAD;
      end
      S_LOAD: begin
        elemReady = 1'b1;
        if (elemValid) begin
          strobe.take = 1'b1;
          if (lastElem) begin
            if (!treeQ) begin
              strobe.chunkEnd = 1'b1;
              stateNext = lastChunk ? S_FIN : S_SETUP;
            end else begin
              stateNext = (MVL > 1) ? S_FOLD : S_MERGE;
            end
          end
        end
      end
      S_FOLD: begin
        strobe.fold = 1'b1;
        if (lastLevel) stateNext = S_MERGE;
      end
      S_MERGE: begin
        strobe.merge    = 1'b1;
        strobe.chunkEnd = 1'b1;
        stateNext = lastChunk ? S_FIN : S_SETUP;
      end
      S_FIN: begin
        done = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/strip_reduce_add.sv
module strip_reduce_add
  import sred_pkg::*;
#(
  parameter int MVL    = 8,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  localparam int LEN_W = $clog2(MVL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  count,
  input  logic              treeMode,
  input  logic              elemValid,
  input  logic [DATA_W-1:0] elemData,
  output logic              elemReady,
  output logic [DATA_W-1:0] result,
  output logic              done,
  output logic [LEN_W-1:0]  chunkLen,
  output logic              chunkStart
);

  sredStrobe_t strobe;
  logic treeQ, countZero, lastElem, lastLevel, lastChunk;

  sred_control #(.MVL(MVL)) i_control (
    .clk(clk), .rstN(rstN), .start(start), .countZero(countZero),
    .treeQ(treeQ), .elemValid(elemValid), .lastElem(lastElem),
    .lastLevel(lastLevel), .lastChunk(lastChunk), .strobe(strobe),
    .elemReady(elemReady), .done(done)
  );

  sred_datapath #(.MVL(MVL), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .countIn(count),
    .treeIn(treeMode), .elemData(elemData), .treeQ(treeQ),
    .countZero(countZero), .lastElem(lastElem), .lastLevel(lastLevel),
    .lastChunk(lastChunk), .acc(result), .lenQ(chunkLen), .pulseQ(chunkStart)
  );

endmodule

// File: rtl/strip_reduce_add_chk.sv
module strip_reduce_add_chk #(
  parameter int MVL    = 8,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  localparam int LEN_W = $clog2(MVL + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [CNT_W-1:0]  count,
  input logic              elemReady,
  input logic [DATA_W-1:0] result,
  input logic              done,
  input logic [LEN_W-1:0]  chunkLen,
  input logic              chunkStart
);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r10_no_ready_at_done: assert property (@(posedge clk) disable iff (!rstN)
    !(done && elemReady));

  a_r2_chunk_bounds: assert property (@(posedge clk) disable iff (!rstN)
    chunkStart |-> (chunkLen != '0 && chunkLen <= LEN_W'(MVL)));

  a_r2_chunk_len_steady: assert property (@(posedge clk) disable iff (!rstN)
    (elemReady && !chunkStart) |-> $stable(chunkLen));

  a_r2_ready_opens_chunk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(elemReady) |-> chunkStart);

  a_r7_zero_count: assert property (@(posedge clk) disable iff (!rstN)
    (start && count == '0 && !elemReady && !done) |=> (done && result == '0));

endmodule

bind strip_reduce_add strip_reduce_add_chk #(.MVL(MVL), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .start(start), .count(count), .elemReady(elemReady),
  .result(result), .done(done), .chunkLen(chunkLen), .chunkStart(chunkStart)
);

// File: tb/test_strip_reduce_add.sv
`timescale 1ns/1ps
module test_strip_reduce_add;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        startS = 1'b0;
  logic [15:0] countS = '0;
  logic        modeS  = 1'b0;

  logic        validA = 1'b0, validB = 1'b0;
  logic [31:0] dataA  = '0,   dataB  = '0;
  logic        readyA, readyB, doneA, doneB, chunkStA, chunkStB;
  logic [31:0] resultA, resultB;
  logic [3:0]  lenA;
  logic [0:0]  lenB;

  strip_reduce_add #(.MVL(8), .CNT_W(16), .DATA_W(32)) i_strip_reduce_add (
    .clk(clk), .rstN(rstN), .start(startS), .count(countS), .treeMode(modeS),
    .elemValid(validA), .elemData(dataA), .elemReady(readyA), .result(resultA),
    .done(doneA), .chunkLen(lenA), .chunkStart(chunkStA)
  );

  strip_reduce_add #(.MVL(1), .CNT_W(16), .DATA_W(32)) i_strip_reduce_add_m1 (
    .clk(clk), .rstN(rstN), .start(startS), .count(countS), .treeMode(modeS),
    .elemValid(validB), .elemData(dataB), .elemReady(readyB), .result(resultB),
    .done(doneB), .chunkLen(lenB), .chunkStart(chunkStB)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;
  logic [31:0] stim [64];
  int nCur = 0;
  bit gapOn = 0;
  int idxA = 0, idxB = 0;
  bit rdyPrevA = 0, rdyPrevB = 0;
  int logA [64];
  int logB [64];
  int logNA = 0, logNB = 0;
  int doneCntA = 0, doneCntB = 0, doneCycA = 0, doneCycB = 0;
  logic [31:0] resAtDoneA = '0, resAtDoneB = '0;

  // Stream feeders and output logging, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (validA && rdyPrevA) idxA++;
    if (validB && rdyPrevB) idxB++;
    rdyPrevA = readyA;
    rdyPrevB = readyB;
    validA = (idxA < nCur) && !(gapOn && (cyc % 3 == 0));
    validB = (idxB < nCur) && !(gapOn && (cyc % 4 == 1));
    dataA  = (idxA < 64) ? stim[idxA] : 32'hDEAD_BEEF;
    dataB  = (idxB < 64) ? stim[idxB] : 32'hDEAD_BEEF;
    if (chunkStA && logNA < 64) begin logA[logNA] = int'(lenA); logNA++; end
    if (chunkStB && logNB < 64) begin logB[logNB] = int'(lenB); logNB++; end
    if (doneA) begin doneCntA++; doneCycA = cyc; resAtDoneA = resultA; end
    if (doneB) begin doneCntB++; doneCycB = cyc; resAtDoneB = resultB; end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkChunks(string req, int n, int mvl, bit isA);
    int rem = n;
    int k = 0;
    bit ok = 1;
    int nLog = isA ? logNA : logNB;
    while (rem > 0) begin
      int vl = (rem < mvl) ? rem : mvl;
      int got = (k < nLog) ? (isA ? logA[k] : logB[k]) : -1;
      if (got != vl) ok = 0;
      rem -= vl;
      k++;
    end
    if (nLog != k) ok = 0;
    check(ok, req, isA ? "chunk lengths mvl8 (count)" : "chunk lengths mvl1 (count)",
          nLog, k);
  endtask

  task automatic runCase(int n, bit tree, bit gaps);
    logic [31:0] expSum = '0;
    int startCyc;
    int guard = 0;
    string mReq = tree ? "R5" : "R4";
    for (int i = 0; i < n; i++) expSum += stim[i];
    nCur = 0;
    tick();
    idxA = 0; idxB = 0; logNA = 0; logNB = 0;
    doneCntA = 0; doneCntB = 0;
    gapOn = gaps;
    nCur = n;
    startS = 1'b1; countS = 16'(n); modeS = tree;
    startCyc = cyc;
    tick();
    // R9: scramble count and mode once start is gone
    startS = 1'b0; countS = 16'(n) ^ 16'h0055; modeS = !tree;
    while ((doneCntA == 0 || doneCntB == 0) && guard < 5000) begin
      tick();
      guard++;
    end
    check(guard < 5000, "R8", "run finished", guard, 0);
    repeat (3) tick();
    check(resAtDoneA == expSum, mReq, "sum mvl8", resAtDoneA, expSum);
    check(resAtDoneB == expSum, "R11", "sum mvl1", resAtDoneB, expSum);
    check(doneCntA == 1 && doneCntB == 1, "R8", "done pulses", doneCntA + doneCntB, 2);
    check(resultA == expSum && !doneA, "R8", "result held after done", resultA, expSum);
    check(idxA == n && idxB == n, "R10", "elements accepted (R9 sampling)", idxA, n);
    checkChunks("R3", n, 8, 1'b1);
    checkChunks("R11", n, 1, 1'b0);
    if (n == 0) begin
      check(doneCycA - startCyc == 1, "R7", "done latency for n=0", doneCycA - startCyc, 1);
      check(resAtDoneA == 0 && resAtDoneB == 0, "R7", "zero result", resAtDoneA, 0);
    end
  endtask

  task automatic fillMixed();
    for (int i = 0; i < 64; i++) stim[i] = 32'(i * 7 - 30);
  endtask

  task automatic fillWrap();
    for (int i = 0; i < 64; i++)
      stim[i] = (i % 3 == 2) ? 32'(-(i * 1000) - 5) : 32'h7FFF_FFF0 + 32'(i);
  endtask

  task automatic resetCheck();
    rstN = 1'b0;
    repeat (3) tick();
    check(!doneA && !readyA && !chunkStA && resultA == 0, "R1", "reset outputs mvl8",
          {doneA, readyA, chunkStA}, 0);
    check(!doneB && !readyB && !chunkStB && resultB == 0, "R1", "reset outputs mvl1",
          {doneB, readyB, chunkStB}, 0);
    rstN = 1'b1;
    tick();
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    fillMixed();
    resetCheck();
    runCase(20, 1'b0, 1'b0);  // R4 R3: chunks 8,8,4
    runCase(20, 1'b1, 1'b0);  // R5
    runCase(20, 1'b1, 1'b1);  // R5 R10 with stalls
    runCase(5, 1'b1, 1'b1);   // R5 padded partial chunk
    runCase(5, 1'b0, 1'b1);   // R4 short run
    runCase(16, 1'b0, 1'b1);  // R3 exact multiple
    runCase(16, 1'b1, 1'b0);
    runCase(1, 1'b1, 1'b0);
    runCase(40, 1'b1, 1'b1);
    fillWrap();
    runCase(11, 1'b0, 1'b0);  // R6 wrap, sequential
    runCase(11, 1'b1, 1'b1);  // R6 wrap, tree
    runCase(0, 1'b0, 1'b0);   // R7
    runCase(0, 1'b1, 1'b0);   // R7
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule